// File: doc/BRIEF.md
# Slow-Bus Cycle Bridge

This block lets a fast processor reach peripherals on a slow, asynchronous-handshake bus. That bus runs on its own clock of roughly 7 MHz, which has no fixed relation to the processor clock. When a processor cycle begins, a combinational decoder looks at the top address nibble and picks one of four targets: the coprocessor, local memory, the expansion daughterboard, or none of these. Only the last target starts a slow-bus cycle. The on-board resources themselves are outside this block; the block only raises their select lines.

A slow-bus cycle begins with a toggle request from the fast domain. A two-flop synchronizer carries it into the slow domain. The slow sequencer runs on the falling edges of the slow clock and drives the address strobe and the two byte-lane data strobes. It samples the slave's acknowledge first on a falling edge and then on the next rising edge. On the falling edge that follows, it latches read data and flips an acknowledge toggle back toward the fast side. A second two-flop synchronizer brings that toggle into the fast domain, where it becomes a one-cycle 16-bit port acknowledge. The same edge also produces a report of the finished transfer. No fast-side timing depends on the ratio between the two clocks.

Fast-side states: F_IDLE (goes to F_BUSY on an off-board cycle, or to F_LOCAL on an on-board one), F_LOCAL (returns to F_IDLE when the cycle strobe drops), F_BUSY (goes to F_HOLD when the acknowledge toggle changes), F_HOLD (returns to F_IDLE when the cycle strobe drops). Slow-side states: S_IDLE (goes to S_ADDR when a request is pending), S_ADDR (goes to S_WAIT), S_WAIT (goes to S_TERM once the acknowledge is seen), S_TERM (goes to S_RECOV), S_RECOV (goes to S_IDLE once the acknowledge is negated).

Top module: `slow_bus_bridge`

## Requirements
- R1: While cpu_as is high, the top address nibble selects the target. 0xE raises sel_cop, 0x2 raises sel_mem and 0xC raises sel_dbrd, in the same cycle and without a clock edge. No other nibble raises a select, at most one select is high at a time, and none is high while cpu_as is low.
- R2: An access that decodes to an on-board target never starts a slow-bus cycle. sb_as_n stays high and cpu_ack16 stays low for the whole access.
- R3: The address strobe sb_as_n falls on a falling edge of clk_s. On a read, the data strobes fall on that same edge. On a write, sb_wdata is driven with sb_wdata_oe high on that edge, and the data strobes fall one slow cycle later.
- R4: The data strobes are active low. A word access (cpu_siz=0) asserts both sb_uds_n and sb_lds_n. A byte access (cpu_siz=1) at an even address asserts only sb_uds_n, and one at an odd address asserts only sb_lds_n. A data strobe is never low while sb_as_n is high.
- R5: sb_dtack_n is sampled on a falling edge of clk_s and then on the next rising edge. On the following falling edge, sb_rdata is latched and the transfer is acknowledged. For reads, cpu_rdata equals the data the slave drove with its acknowledge.
- R6: The strobes are negated on the falling edge after the latch edge. A slave that drives sb_dtack_n low just after rising edge k therefore sees the strobes high at rising edge k+3. No new cycle starts while sb_dtack_n is still low.
- R7: During a write, sb_wdata holds the written value without change from the address strobe until the strobes are negated.
- R8: Each slow-bus transfer produces exactly one cpu_ack16 pulse, one fast cycle wide. With that pulse come xfer_rw, xfer_addr and xfer_data: read data for reads, write data for writes. Transfers complete in the order they were issued.
- R9: After reset, sb_as_n, sb_uds_n, sb_lds_n and sb_rw are high, and sb_wdata_oe and cpu_ack16 are low.
- R10: A transfer completes correctly whatever number of slow-clock wait states the slave inserts before acknowledging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_f | input | 1 | Fast processor clock |
| rst_f_n | input | 1 | Fast-domain reset, active low |
| clk_s | input | 1 | Slow bus clock |
| rst_s_n | input | 1 | Slow-domain reset, active low |
| cpu_as | input | 1 | Processor cycle active, held until acknowledged |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_siz | input | 1 | 1 = byte, 0 = word |
| cpu_wdata | input | DATA_W | Processor write data |
| sel_cop | output | 1 | Coprocessor select |
| sel_mem | output | 1 | Local memory select |
| sel_dbrd | output | 1 | Daughterboard select |
| cpu_ack16 | output | 1 | 16-bit port acknowledge pulse |
| cpu_rdata | output | DATA_W | Read data returned to the processor |
| xfer_rw | output | 1 | Direction of the completed transfer |
| xfer_addr | output | ADDR_W | Address of the completed transfer |
| xfer_data | output | DATA_W | Data of the completed transfer |
| sb_as_n | output | 1 | Slow-bus address strobe, active low |
| sb_uds_n | output | 1 | Upper-byte data strobe, active low |
| sb_lds_n | output | 1 | Lower-byte data strobe, active low |
| sb_rw | output | 1 | Slow-bus direction, 1 = read |
| sb_addr | output | ADDR_W-1 | Slow-bus word address (byte address bits above bit 0) |
| sb_wdata | output | DATA_W | Slow-bus write data |
| sb_wdata_oe | output | 1 | Write data drive enable |
| sb_rdata | input | DATA_W | Slow-bus read data |
| sb_dtack_n | input | 1 | Slave transfer acknowledge, active low |

## Verification
Slow-side results sit at fixed distances in slow-clock edges, so the slave model samples on rising edges of clk_s and counts them. It expects the strobe pattern of R3 at the first rising edge after the address strobe falls. It expects the strobe negation of R6 at exactly the third rising edge after it drives the acknowledge. It drives its own outputs 2 ns after a rising edge, so they never change at an edge the design samples. The fast-side acknowledge has no fixed cycle count, because two synchronizers and an unrelated clock ratio lie on its path. The driver therefore samples at falling edges of clk_f, waits for cpu_ack16 with a bound, and then checks the report fields and confirms the pulse is gone one cycle later.

// File: rtl/slb_pkg.sv
package slb_pkg;

    typedef enum logic [1:0] {
        TGT_COP,
        TGT_MEM,
        TGT_DBRD,
        TGT_SLOW
    } tgt_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_LOCAL,
        F_BUSY,
        F_HOLD
    } fst_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_WAIT,
        S_TERM,
        S_RECOV
    } sst_e;

endpackage

// File: rtl/slb_sync2.sv
module slb_sync2 #(
    parameter int STAGES   = 2,
    parameter bit NEG_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sr;

    generate
        if (NEG_EDGE) begin : g_neg
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
        end else begin : g_pos
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];

endmodule

// File: rtl/slb_decode.sv
module slb_decode
    import slb_pkg::*;
#(
    parameter int             TAG_W    = 4,
    parameter logic [TAG_W-1:0] COP_TAG  = 'hE,
    parameter logic [TAG_W-1:0] MEM_TAG  = 'h2,
    parameter logic [TAG_W-1:0] DBRD_TAG = 'hC
) (
    input  logic [TAG_W-1:0] tag,
    input  logic             cyc,
    output tgt_e             tgt,
    output logic             sel_cop,
    output logic             sel_mem,
    output logic             sel_dbrd
);

    always_comb begin
        if      (tag == COP_TAG)  tgt = TGT_COP;
        else if (tag == MEM_TAG)  tgt = TGT_MEM;
        else if (tag == DBRD_TAG) tgt = TGT_DBRD;
        else                      tgt = TGT_SLOW;
        sel_cop  = cyc && (tgt == TGT_COP);
        sel_mem  = cyc && (tgt == TGT_MEM);
        sel_dbrd = cyc && (tgt == TGT_DBRD);
    end

    // R1
    always_comb begin
        sel_onehot_chk: assert ($onehot0({sel_cop, sel_mem, sel_dbrd}));
    end

endmodule

// File: rtl/slb_fast_ctl.sv
module slb_fast_ctl
    import slb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_as,
    input  tgt_e              tgt,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_siz,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              ack_sync,
    input  logic [DATA_W-1:0] rd_hold,
    output logic              req_tgl,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_rw,
    output logic              cap_siz,
    output logic [DATA_W-1:0] cap_wdata,
    output logic              cpu_ack16,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              xfer_rw,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [DATA_W-1:0] xfer_data
);

    fst_e state, nxt;
    logic ack_prev;
    logic ack_edge;

    assign ack_edge = ack_sync ^ ack_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            F_IDLE:  if (cpu_as) nxt = (tgt == TGT_SLOW) ? F_BUSY : F_LOCAL;
            F_LOCAL: if (!cpu_as) nxt = F_IDLE;
            F_BUSY:  if (ack_edge) nxt = F_HOLD;
            F_HOLD:  if (!cpu_as) nxt = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl   <= 1'b0;
            cap_addr  <= '0;
            cap_rw    <= 1'b1;
            cap_siz   <= 1'b0;
            cap_wdata <= '0;
            cpu_ack16 <= 1'b0;
            cpu_rdata <= '0;
            xfer_rw   <= 1'b1;
            xfer_addr <= '0;
            xfer_data <= '0;
            ack_prev  <= 1'b0;
        end else begin
            cpu_ack16 <= 1'b0;
            ack_prev  <= ack_sync;
            if (state == F_IDLE && cpu_as && tgt == TGT_SLOW) begin
                cap_addr  <= cpu_addr;
                cap_rw    <= cpu_rw;
                cap_siz   <= cpu_siz;
                cap_wdata <= cpu_wdata;
                req_tgl   <= ~req_tgl;
            end
            if (state == F_BUSY && ack_edge) begin
                cpu_ack16 <= 1'b1;
                xfer_rw   <= cap_rw;
                xfer_addr <= cap_addr;
                xfer_data <= cap_rw ? rd_hold : cap_wdata;
                if (cap_rw) cpu_rdata <= rd_hold;
            end
        end
    end

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack16 |=> !cpu_ack16);

    // R2
    slow_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_tgl != $past(req_tgl)) |-> $past(cpu_as && tgt == TGT_SLOW));

endmodule

// File: rtl/slb_slow_seq.sv
module slb_slow_seq
    import slb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              cap_rw,
    input  logic              cap_siz,
    input  logic [DATA_W-1:0] cap_wdata,
    input  logic              sb_dtack_n,
    input  logic [DATA_W-1:0] sb_rdata,
    output logic              sb_as_n,
    output logic              sb_uds_n,
    output logic              sb_lds_n,
    output logic              sb_rw,
    output logic [ADDR_W-2:0] sb_addr,
    output logic [DATA_W-1:0] sb_wdata,
    output logic              sb_wdata_oe,
    output logic              ack_tgl,
    output logic [DATA_W-1:0] rd_hold
);

    sst_e state, nxt;
    logic req_seen;
    logic pend;
    logic dtk_f, dtk_r;
    logic lane_u, lane_l;
    logic want_u, want_l;
    logic siz_q;

    assign pend   = req_sync ^ req_seen;
    assign want_u = !(cap_siz && cap_addr[0]);
    assign want_l = !(cap_siz && !cap_addr[0]);

    // acknowledge seen on a falling edge, then re-sampled on the rising edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) dtk_f <= 1'b0;
        else        dtk_f <= ~sb_dtack_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dtk_r <= 1'b0;
        else        dtk_r <= dtk_f;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (pend) nxt = S_ADDR;
            S_ADDR:  nxt = S_WAIT;
            S_WAIT:  if (dtk_r) nxt = S_TERM;
            S_TERM:  nxt = S_RECOV;
            S_RECOV: if (!dtk_r) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_seen    <= 1'b0;
            sb_as_n     <= 1'b1;
            sb_uds_n    <= 1'b1;
            sb_lds_n    <= 1'b1;
            sb_rw       <= 1'b1;
            sb_addr     <= '0;
            sb_wdata    <= '0;
            sb_wdata_oe <= 1'b0;
            ack_tgl     <= 1'b0;
            rd_hold     <= '0;
            lane_u      <= 1'b0;
            lane_l      <= 1'b0;
            siz_q       <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (pend) begin
                        req_seen <= ~req_seen;
                        sb_addr  <= cap_addr[ADDR_W-1:1];
                        sb_rw    <= cap_rw;
                        sb_as_n  <= 1'b0;
                        lane_u   <= want_u;
                        lane_l   <= want_l;
                        siz_q    <= cap_siz;
                        if (cap_rw) begin
                            sb_uds_n <= ~want_u;
                            sb_lds_n <= ~want_l;
                        end else begin
                            sb_wdata    <= cap_wdata;
                            sb_wdata_oe <= 1'b1;
                        end
                    end
                end
                S_ADDR: begin
                    if (!sb_rw) begin
                        sb_uds_n <= ~lane_u;
                        sb_lds_n <= ~lane_l;
                    end
                end
                S_WAIT: begin
                    if (dtk_r) begin
                        if (sb_rw) rd_hold <= sb_rdata;
                        ack_tgl <= ~ack_tgl;
                    end
                end
                S_TERM: begin
                    sb_as_n     <= 1'b1;
                    sb_uds_n    <= 1'b1;
                    sb_lds_n    <= 1'b1;
                    sb_wdata_oe <= 1'b0;
                    sb_rw       <= 1'b1;
                end
                S_RECOV: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R4
    ds_needs_as_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (!sb_uds_n || !sb_lds_n) |-> !sb_as_n);

    // R4
    byte_lane_chk: assert property (@(negedge clk) disable iff (!rst_n)
        ((!sb_uds_n || !sb_lds_n) && siz_q) |-> ($countones({~sb_uds_n, ~sb_lds_n}) == 1));

    // R7
    wdata_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (!sb_rw && !sb_as_n && $past(!sb_as_n)) |-> $stable(sb_wdata));

    // R5
    ack_after_dtack_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (ack_tgl != $past(ack_tgl)) |-> $past(dtk_r));

    // R6
    no_restart_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(sb_as_n) |-> !$past(dtk_r));

endmodule

// File: rtl/slow_bus_bridge.sv
module slow_bus_bridge
    import slb_pkg::*;
#(
    parameter int             ADDR_W      = 24,
    parameter int             DATA_W      = 16,
    parameter int             TAG_W       = 4,
    parameter int             SYNC_STAGES = 2,
    parameter logic [TAG_W-1:0] COP_TAG     = 'hE,
    parameter logic [TAG_W-1:0] MEM_TAG     = 'h2,
    parameter logic [TAG_W-1:0] DBRD_TAG    = 'hC
) (
    input  logic              clk_f,
    input  logic              rst_f_n,
    input  logic              clk_s,
    input  logic              rst_s_n,
    input  logic              cpu_as,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              cpu_siz,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              sel_cop,
    output logic              sel_mem,
    output logic              sel_dbrd,
    output logic              cpu_ack16,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              xfer_rw,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [DATA_W-1:0] xfer_data,
    output logic              sb_as_n,
    output logic              sb_uds_n,
    output logic              sb_lds_n,
    output logic              sb_rw,
    output logic [ADDR_W-2:0] sb_addr,
    output logic [DATA_W-1:0] sb_wdata,
    output logic              sb_wdata_oe,
    input  logic [DATA_W-1:0] sb_rdata,
    input  logic              sb_dtack_n
);

    tgt_e              tgt;
    logic              req_tgl, req_sync;
    logic              ack_tgl, ack_sync;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_rw, cap_siz;
    logic [DATA_W-1:0] cap_wdata;
    logic [DATA_W-1:0] rd_hold;

    slb_decode #(
        .TAG_W(TAG_W), .COP_TAG(COP_TAG), .MEM_TAG(MEM_TAG), .DBRD_TAG(DBRD_TAG)
    ) u_dec (
        .tag(cpu_addr[ADDR_W-1 -: TAG_W]), .cyc(cpu_as), .tgt(tgt),
        .sel_cop(sel_cop), .sel_mem(sel_mem), .sel_dbrd(sel_dbrd)
    );

    slb_fast_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fast (
        .clk(clk_f), .rst_n(rst_f_n), .cpu_as(cpu_as), .tgt(tgt),
        .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_siz(cpu_siz), .cpu_wdata(cpu_wdata),
        .ack_sync(ack_sync), .rd_hold(rd_hold), .req_tgl(req_tgl),
        .cap_addr(cap_addr), .cap_rw(cap_rw), .cap_siz(cap_siz), .cap_wdata(cap_wdata),
        .cpu_ack16(cpu_ack16), .cpu_rdata(cpu_rdata),
        .xfer_rw(xfer_rw), .xfer_addr(xfer_addr), .xfer_data(xfer_data)
    );

    slb_sync2 #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1)) u_req_sync (
        .clk(clk_s), .rst_n(rst_s_n), .d(req_tgl), .q(req_sync)
    );

    slb_sync2 #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) u_ack_sync (
        .clk(clk_f), .rst_n(rst_f_n), .d(ack_tgl), .q(ack_sync)
    );

    slb_slow_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slow (
        .clk(clk_s), .rst_n(rst_s_n), .req_sync(req_sync),
        .cap_addr(cap_addr), .cap_rw(cap_rw), .cap_siz(cap_siz), .cap_wdata(cap_wdata),
        .sb_dtack_n(sb_dtack_n), .sb_rdata(sb_rdata),
        .sb_as_n(sb_as_n), .sb_uds_n(sb_uds_n), .sb_lds_n(sb_lds_n), .sb_rw(sb_rw),
        .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_wdata_oe(sb_wdata_oe),
        .ack_tgl(ack_tgl), .rd_hold(rd_hold)
    );

endmodule

// File: tb/slow_bus_bridge_tb.sv
`timescale 1ns/1ps
module slow_bus_bridge_tb;

    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk_f = 1'b0, clk_s = 1'b0;
    logic          rst_f_n = 1'b0, rst_s_n = 1'b0;
    logic          cpu_as = 1'b0, cpu_rw = 1'b1, cpu_siz = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          sel_cop, sel_mem, sel_dbrd, cpu_ack16, xfer_rw;
    logic [DW-1:0] cpu_rdata, xfer_data, sb_wdata;
    logic [AW-1:0] xfer_addr;
    logic          sb_as_n, sb_uds_n, sb_lds_n, sb_rw, sb_wdata_oe;
    logic [AW-2:0] sb_addr;
    logic [DW-1:0] sb_rdata = '0;
    logic          sb_dtack_n = 1'b1;

    int n_chk = 0, n_fail = 0, exp_cnt = 0, sl_cnt = 0;
    logic [AW-2:0] sl_addr;
    logic          sl_rw, sl_u, sl_l;
    logic [DW-1:0] sl_wd;

    always #2.5 clk_f = ~clk_f;
    always #70.5 clk_s = ~clk_s;

    slow_bus_bridge u_dut (
        .clk_f(clk_f), .rst_f_n(rst_f_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
        .cpu_as(cpu_as), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_siz(cpu_siz),
        .cpu_wdata(cpu_wdata), .sel_cop(sel_cop), .sel_mem(sel_mem), .sel_dbrd(sel_dbrd),
        .cpu_ack16(cpu_ack16), .cpu_rdata(cpu_rdata), .xfer_rw(xfer_rw),
        .xfer_addr(xfer_addr), .xfer_data(xfer_data), .sb_as_n(sb_as_n),
        .sb_uds_n(sb_uds_n), .sb_lds_n(sb_lds_n), .sb_rw(sb_rw), .sb_addr(sb_addr),
        .sb_wdata(sb_wdata), .sb_wdata_oe(sb_wdata_oe), .sb_rdata(sb_rdata),
        .sb_dtack_n(sb_dtack_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_rd(input logic [AW-2:0] wa);
        return wa[15:0] ^ {9'h000, wa[22:16]} ^ 16'h5A3C;
    endfunction

    // slow-bus slave model with random wait states
    initial begin
        int ws, hold, n;
        forever begin
            @(posedge clk_s);
            if (!rst_s_n || sb_as_n) continue;
            check(sb_dtack_n === 1'b1, "R6 no start while acknowledge low", sb_dtack_n, 1);
            if (sb_rw)
                check(!sb_uds_n || !sb_lds_n, "R3 read strobes with address strobe",
                      {sb_uds_n, sb_lds_n}, 0);
            else
                check(sb_uds_n && sb_lds_n && sb_wdata_oe, "R3 write strobes one cycle later",
                      {sb_uds_n, sb_lds_n, sb_wdata_oe}, 3'b111);
            while (sb_uds_n && sb_lds_n) @(posedge clk_s);
            sl_addr = sb_addr; sl_rw = sb_rw; sl_u = !sb_uds_n; sl_l = !sb_lds_n; sl_wd = sb_wdata;
            sl_cnt++;
            ws = int'($urandom % 5);
            repeat (ws) begin
                @(posedge clk_s);
                if (!sl_rw) check(sb_wdata == sl_wd, "R7 write data held", sb_wdata, sl_wd);
            end
            #2;
            sb_rdata   = exp_rd(sb_addr);
            sb_dtack_n = 1'b0;
            n = 0;
            do begin
                @(posedge clk_s);
                n++;
                if (!sb_as_n && !sl_rw) check(sb_wdata == sl_wd, "R7 write data held", sb_wdata, sl_wd);
            end while (!sb_as_n && n < 50);
            check(n == 3, "R6 strobes negate at third rising edge", n, 3);
            hold = int'($urandom % 3);
            repeat (hold) @(posedge clk_s);
            #2 sb_dtack_n = 1'b1;
        end
    end

    task automatic xfer(input logic [AW-1:0] a, input logic rw, input logic siz, input logic [DW-1:0] wd);
        int k;
        logic eu, el;
        @(negedge clk_f);
        cpu_addr = a; cpu_rw = rw; cpu_siz = siz; cpu_wdata = wd; cpu_as = 1'b1;
        #1 check(!sel_cop && !sel_mem && !sel_dbrd, "R1 off-board address raises no select",
                 {sel_cop, sel_mem, sel_dbrd}, 0);
        k = 0;
        while (!cpu_ack16 && k < 20000) begin @(negedge clk_f); k++; end
        exp_cnt++;
        check(cpu_ack16, "R10 transfer completes with wait states", cpu_ack16, 1);
        if (cpu_ack16) begin
            eu = !(siz && a[0]);
            el = !(siz && !a[0]);
            check(xfer_addr == a, "R8 report address", xfer_addr, a);
            check(xfer_rw == rw, "R8 report direction", xfer_rw, rw);
            check(xfer_data == (rw ? exp_rd(a[AW-1:1]) : wd), "R8 report data", xfer_data,
                  rw ? exp_rd(a[AW-1:1]) : wd);
            if (rw) check(cpu_rdata == exp_rd(a[AW-1:1]), "R5 read data latched", cpu_rdata,
                          exp_rd(a[AW-1:1]));
            check(sl_cnt == exp_cnt, "R8 transfers in order", sl_cnt, exp_cnt);
            check(sl_addr == a[AW-1:1] && sl_rw == rw, "R3 slow-bus address and direction",
                  {sl_rw, sl_addr}, {rw, a[AW-1:1]});
            check({sl_u, sl_l} == {eu, el}, "R4 byte lanes", {sl_u, sl_l}, {eu, el});
            if (!rw) check(sl_wd == wd, "R7 write data on bus", sl_wd, wd);
        end
        @(negedge clk_f);
        check(!cpu_ack16, "R8 single-cycle acknowledge", cpu_ack16, 0);
        cpu_as = 1'b0;
        k = 0;
        repeat (3) begin @(negedge clk_f); if (cpu_ack16) k++; end
        check(k == 0, "R8 no extra acknowledge", k, 0);
    endtask

    task automatic onboard(input logic [3:0] tag);
        int bad;
        @(negedge clk_f);
        cpu_addr = {tag, 20'h1_2345}; cpu_rw = 1'b1; cpu_siz = 1'b0; cpu_as = 1'b1;
        #1 check({sel_cop, sel_mem, sel_dbrd} == {tag == 4'hE, tag == 4'h2, tag == 4'hC},
                 "R1 on-board select", {sel_cop, sel_mem, sel_dbrd},
                 {tag == 4'hE, tag == 4'h2, tag == 4'hC});
        bad = 0;
        repeat (150) begin @(negedge clk_f); if (!sb_as_n || cpu_ack16) bad++; end
        check(bad == 0, "R2 on-board access starts no slow cycle", bad, 0);
        cpu_as = 1'b0;
        #1 check(!sel_cop && !sel_mem && !sel_dbrd, "R1 no select without cycle",
                 {sel_cop, sel_mem, sel_dbrd}, 0);
        repeat (3) @(negedge clk_f);
    endtask

    initial begin
        repeat (150000) @(posedge clk_f);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        #300;
        rst_s_n = 1'b1;
        @(negedge clk_f); rst_f_n = 1'b1;
        repeat (4) @(negedge clk_f);
        check(sb_as_n && sb_uds_n && sb_lds_n && sb_rw && !sb_wdata_oe && !cpu_ack16,
              "R9 reset state", {sb_as_n, sb_uds_n, sb_lds_n, sb_rw, sb_wdata_oe, cpu_ack16},
              6'b111100);
        onboard(4'hE);
        onboard(4'h2);
        onboard(4'hC);
        xfer(24'h40_0010, 1'b1, 1'b0, 16'h0000);
        xfer(24'h41_0022, 1'b1, 1'b1, 16'h0000);
        xfer(24'h41_0023, 1'b1, 1'b1, 16'h0000);
        xfer(24'h80_0101, 1'b0, 1'b1, 16'hBEEF);
        xfer(24'h80_0100, 1'b0, 1'b1, 16'h1234);
        xfer(24'hF0_FFFE, 1'b0, 1'b0, 16'hC0DE);
        for (int i = 0; i < 40; i++) begin
            logic [31:0] r;
            logic [3:0]  t;
            r = $urandom;
            t = r[27:24];
            if (t == 4'hE || t == 4'h2 || t == 4'hC) t = 4'h7;
            xfer({t, r[19:0]}, r[31], r[30], r[15:0] ^ r[29:14]);
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule